// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM of 128K bytes. The host offers one access at a time over a request/ready handshake: a 17-bit word address, an 8-bit write value and a direction flag. Read results come back on a data port qualified by a one-cycle valid strobe. On the memory side the block drives active-low chip-select, output-enable and write-strobe lines and the address lines. The data lines are carried as separate input and output buses, with a drive-enable for the pad drivers.

Each access is built from timed phases. A read holds chip-select and output-enable low for a fixed count of clocks and captures the data in the last of them. A quiet turnaround period follows, with all strobes high. A write first sets up the address with chip-select low, then pulses the write strobe low while the data is driven. A hold period follows, with the strobe high again and the address and data unchanged. Output-enable stays high for the whole write, so the memory never drives the data lines while the block does. After reset the block refuses all requests until a power-up delay has elapsed.

The phase lengths are parameters. Their defaults come from the memory's nanosecond timings, divided by the clock period and rounded up to whole clocks.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is asserted and in the cycle after it, host_ready and host_rvalid are low, mem_ce_n, mem_oe_n and mem_we_n are high, and mem_dq_oe is low.
- R2: After reset is released, host_ready stays low for exactly PWRUP_CYC clock cycles and then goes high. No memory strobe falls during that time.
- R3: A request is taken on a clock edge where host_req and host_ready are both high. host_ready then stays low for RD_CYC+TURN_CYC cycles after a read and for SETUP_CYC+WE_CYC+HOLD_CYC cycles after a write.
- R4: A read holds mem_ce_n and mem_oe_n low with mem_we_n high for exactly RD_CYC cycles. host_rvalid then pulses high for one cycle. host_rdata carries the value the memory drove in the last of those cycles.
- R5: A write holds mem_ce_n low with mem_we_n high for SETUP_CYC cycles, then mem_we_n low for WE_CYC cycles, then mem_we_n high with mem_ce_n still low for HOLD_CYC cycles. mem_oe_n is high throughout. mem_we_n is never low while mem_ce_n is high.
- R6: mem_addr does not change while mem_ce_n is low. mem_dq_out does not change while mem_dq_oe is high. Both are the values captured when the request was taken.
- R7: mem_dq_oe is high only during the write-strobe-low and hold phases of a write.
- R8: mem_dq_oe is never high while mem_oe_n is low. After mem_oe_n rises at the end of a read, neither mem_dq_oe nor mem_ce_n goes low for at least TURN_CYC+1 cycles.
- R9: Data written to an address is returned by a later read of the same address.
- R10: host_req while host_ready is low has no effect: no memory access starts and no memory word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 8 | Write value |
| host_ready | output | 1 | Block idle and accepting a request |
| host_rdata | output | 8 | Last read value |
| host_rvalid | output | 1 | One-cycle strobe for new host_rdata |
| mem_ce_n | output | 1 | Memory chip-select, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 17 | Memory address lines |
| mem_dq_out | output | 8 | Data to the pad drivers |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | 8 | Data from the pads |

## Verification
The bench uses a power-up count of 50 so that the whole wait can be counted cycle by cycle. It sets the read phase to 2 cycles, the address setup to 2, the write strobe to 3, the hold to 1 and the turnaround to 2. These multi-cycle phase lengths let the bench check the exact length of every strobe phase and the gap after a read, not just the single-clock default case. Its memory model keeps a 64-word window that aliases on the low address bits, so random traffic revisits the same words often and exercises read-after-write.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_PWRUP  = 3'd0,
        PH_IDLE   = 3'd1,
        PH_RACC   = 3'd2,
        PH_TURN   = 3'd3,
        PH_WSETUP = 3'd4,
        PH_WPULSE = 3'd5,
        PH_WHOLD  = 3'd6
    } phase_e;

    // Registered pin image of the memory control lines
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // Whole clock periods covering a time in ns, never below one
    function automatic int cyc_for(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic strobe_t strobe_of(input phase_e ph);
        strobe_t s;
        s = STROBE_IDLE;
        case (ph)
            PH_RACC:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
            PH_WSETUP: begin s.ce_n = 1'b0; end
            PH_WPULSE: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.drive = 1'b1; end
            PH_WHOLD:  begin s.ce_n = 1'b0; s.drive = 1'b1; end
            default:   s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_pwrup_gate.sv
module sram_pwrup_gate #(
    parameter int PWRUP_CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic pwr_ok
);
    localparam int CW = $clog2(PWRUP_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q != CW'(PWRUP_CYC))
            cnt_q <= cnt_q + 1'b1;
    end

    assign pwr_ok = (cnt_q == CW'(PWRUP_CYC));

    AST_PWRUP_STAYS_OK: assert property (@(posedge clk) disable iff (rst)
        pwr_ok |=> pwr_ok); // R2

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC    = 1,
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = 1,
    parameter int HOLD_CYC  = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pwr_ok,
    input  logic   req,
    input  logic   we,
    output phase_e ph_q,
    output phase_e ph_nxt,
    output logic   accept,
    output logic   rd_sample
);
    localparam int M1 = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
    localparam int M2 = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
    localparam int M3 = (M1 > M2) ? M1 : M2;
    localparam int PH_MAX = (M3 > HOLD_CYC) ? M3 : HOLD_CYC;
    localparam int TW = (PH_MAX < 2) ? 1 : $clog2(PH_MAX);

    logic          done;
    logic [TW-1:0] len_m1;

    always_comb begin
        case (ph_nxt)
            PH_RACC:   len_m1 = TW'(RD_CYC - 1);
            PH_TURN:   len_m1 = TW'(TURN_CYC - 1);
            PH_WSETUP: len_m1 = TW'(SETUP_CYC - 1);
            PH_WPULSE: len_m1 = TW'(WE_CYC - 1);
            PH_WHOLD:  len_m1 = TW'(HOLD_CYC - 1);
            default:   len_m1 = '0;
        endcase
    end

    sram_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ph_nxt != ph_q),
        .load_val (len_m1),
        .done     (done)
    );

    always_comb begin
        ph_nxt = ph_q;
        accept = 1'b0;
        case (ph_q)
            PH_PWRUP:  if (pwr_ok) ph_nxt = PH_IDLE;
            PH_IDLE:   if (req) begin
                           accept = 1'b1;
                           ph_nxt = we ? PH_WSETUP : PH_RACC;
                       end
            PH_RACC:   if (done) ph_nxt = PH_TURN;
            PH_TURN:   if (done) ph_nxt = PH_IDLE;
            PH_WSETUP: if (done) ph_nxt = PH_WPULSE;
            PH_WPULSE: if (done) ph_nxt = PH_WHOLD;
            PH_WHOLD:  if (done) ph_nxt = PH_IDLE;
            default:   ph_nxt = PH_PWRUP;
        endcase
    end

    assign rd_sample = (ph_q == PH_RACC) && done;

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= PH_PWRUP;
        else
            ph_q <= ph_nxt;
    end

    AST_NO_START_BEFORE_PWR: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |-> !accept); // R2

    AST_READ_ENDS_IN_TURN: assert property (@(posedge clk) disable iff (rst)
        rd_sample |=> (ph_q == PH_TURN)); // R8

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int PWRUP_CYC = cyc_for(100000, CLK_NS),
    parameter int RD_CYC    = cyc_for(10, CLK_NS),
    parameter int SETUP_CYC = 1,
    parameter int WE_CYC    = cyc_for(8, CLK_NS),
    parameter int HOLD_CYC  = 1,
    parameter int TURN_CYC  = cyc_for(5, CLK_NS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic              pwr_ok;
    phase_e            ph_q;
    phase_e            ph_nxt;
    logic              accept;
    logic              rd_sample;
    strobe_t           strb_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    sram_pwrup_gate #(.PWRUP_CYC(PWRUP_CYC)) u_pwrup (
        .clk    (clk),
        .rst    (rst),
        .pwr_ok (pwr_ok)
    );

    sram_seq #(
        .RD_CYC    (RD_CYC),
        .SETUP_CYC (SETUP_CYC),
        .WE_CYC    (WE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok    (pwr_ok),
        .req       (host_req),
        .we        (host_we),
        .ph_q      (ph_q),
        .ph_nxt    (ph_nxt),
        .accept    (accept),
        .rd_sample (rd_sample)
    );

    // Strobes come straight from flops so the pins never glitch
    always_ff @(posedge clk) begin
        if (rst)
            strb_q <= STROBE_IDLE;
        else
            strb_q <= strobe_of(ph_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
            end
            if (rd_sample)
                rdata_q <= mem_dq_in;
            rvalid_q <= rd_sample;
        end
    end

    assign host_ready  = (ph_q == PH_IDLE);
    assign host_rdata  = rdata_q;
    assign host_rvalid = rvalid_q;
    assign mem_ce_n    = strb_q.ce_n;
    assign mem_oe_n    = strb_q.oe_n;
    assign mem_we_n    = strb_q.we_n;
    assign mem_dq_oe   = strb_q.drive;
    assign mem_addr    = addr_q;
    assign mem_dq_out  = wdata_q;

    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |-> (!host_ready && mem_ce_n)); // R2

    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R5

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R6

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R6

    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_ce_n && mem_oe_n)); // R7

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe); // R8

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (mem_ce_n && !mem_dq_oe)); // R8

    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid); // R4

    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (rst)
        !host_ready |-> !accept); // R10

endmodule

// File: tb/tb_sram_async_ctl.sv
module tb_sram_async_ctl;

    localparam int AW = 17;
    localparam int DW = 8;
    localparam int P_PWRUP = 50;
    localparam int P_RD    = 2;
    localparam int P_SETUP = 2;
    localparam int P_WE    = 3;
    localparam int P_HOLD  = 1;
    localparam int P_TURN  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ready, host_rvalid;
    logic [DW-1:0] host_rdata;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    always #5 clk = ~clk;

    sram_async_ctl #(
        .PWRUP_CYC (P_PWRUP),
        .RD_CYC    (P_RD),
        .SETUP_CYC (P_SETUP),
        .WE_CYC    (P_WE),
        .HOLD_CYC  (P_HOLD),
        .TURN_CYC  (P_TURN)
    ) dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory with a 64-word window plus protocol monitors
    logic [DW-1:0] model_mem [64];
    logic [DW-1:0] ref_mem   [64];
    int viol_strobe = 0, viol_bus = 0, viol_addr = 0, viol_pwr = 0;
    int we_run = 0, oe_run = 0, ce_run = 0, hold_run = 0, since_oe = 1000;
    logic after_we = 1'b0;
    logic pce = 1'b1, poe = 1'b1, pwe = 1'b1, pdrv = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pdq = '0;

    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model_mem[mem_addr[5:0]] : 8'h00;

    always @(negedge clk) begin
        if (rst) begin
            we_run = 0; oe_run = 0; ce_run = 0; hold_run = 0; since_oe = 1000;
            after_we = 1'b0; pce = 1'b1; poe = 1'b1; pwe = 1'b1; pdrv = 1'b0;
        end else begin
            if (!host_ready && !mem_ce_n && pce && dut_in_pwrup) viol_pwr++;
            if (!mem_we_n && (mem_ce_n || !mem_oe_n)) viol_strobe++;        // R5
            if (!mem_we_n && pwe && ce_run != P_SETUP) viol_strobe++;       // R5
            if (!mem_we_n) we_run++;
            if (mem_we_n && !pwe) begin
                if (we_run != P_WE) viol_strobe++;                          // R5
                if (!pdrv) viol_bus++;
                model_mem[mem_addr[5:0]] = mem_dq_out;
                we_run = 0; after_we = 1'b1; hold_run = 0;
            end
            if (after_we && !mem_ce_n && mem_we_n) hold_run++;
            if (mem_ce_n && !pce && after_we) begin
                if (hold_run != P_HOLD) viol_strobe++;                      // R5
                after_we = 1'b0;
            end
            if (!mem_oe_n) oe_run++;
            if (mem_oe_n && !poe) begin
                if (oe_run != P_RD) viol_strobe++;                          // R4
                oe_run = 0; since_oe = 0;
            end
            if (mem_oe_n && since_oe < 1000) since_oe++;
            if (mem_dq_oe && (!mem_oe_n || mem_ce_n)) viol_bus++;           // R7 R8
            if (mem_dq_oe && !after_we && mem_we_n) viol_bus++;             // R7
            if ((mem_dq_oe || !mem_ce_n) && since_oe <= P_TURN) viol_bus++; // R8
            if (!mem_ce_n && !pce && mem_addr != paddr) viol_addr++;        // R6
            if (mem_dq_oe && pdrv && mem_dq_out != pdq) viol_addr++;        // R6
            if (!mem_ce_n && mem_we_n && mem_oe_n && !after_we) ce_run++;
            if (mem_ce_n) ce_run = 0;
            pce = mem_ce_n; poe = mem_oe_n; pwe = mem_we_n; pdrv = mem_dq_oe;
            paddr = mem_addr; pdq = mem_dq_out;
        end
    end

    logic dut_in_pwrup = 1'b1;

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_busy(input bit we);
        return we ? (P_SETUP + P_WE + P_HOLD) : (P_RD + P_TURN);
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        return ref_mem[a[5:0]];
    endfunction

    // One access; optional one-cycle stray request while busy (R10)
    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit poke, output logic [DW-1:0] rd);
        int busy = 0, nval = 0;
        rd = '0;
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        while (!host_ready) begin
            busy++;
            if (host_rvalid) begin nval++; rd = host_rdata; end
            if (poke && busy == 1) begin
                host_req = 1'b1; host_we = 1'b1;
                host_addr = a ^ 17'h00015; host_wdata = ~d;
            end else begin
                host_req = 1'b0;
            end
            @(negedge clk);
        end
        host_req = 1'b0;
        chk(busy == exp_busy(we), "R3 busy length", busy, exp_busy(we));
        chk(nval == (we ? 0 : 1), "R4 rvalid pulse count", nval, we ? 0 : 1);
        if (we) ref_mem[a[5:0]] = d;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin model_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
    end

    initial begin
        logic [DW-1:0] r;
        int low;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!host_ready && !host_rvalid && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R1 reset outputs", {host_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b01110);
        rst = 1'b0;
        low = 0;
        // R2/R10: count power-up wait while poking requests
        forever begin
            @(negedge clk);
            if (host_ready) break;
            low++;
            host_req = (low > 5 && low < 10); host_we = 1'b1;
            host_addr = 17'h00003; host_wdata = 8'hA5;
            if (!mem_ce_n) viol_pwr++;
        end
        host_req = 1'b0;
        dut_in_pwrup = 1'b0;
        chk(low == P_PWRUP, "R2 power-up wait", low, P_PWRUP);
        chk(viol_pwr == 0, "R2 strobes quiet in power-up", viol_pwr, 0);
        // R10: stray request during power-up wrote nothing
        access(1'b0, 17'h00003, 8'h00, 1'b0, r);
        chk(r == 8'h00, "R10 no write during power-up", r, 8'h00);
        // R9: directed corner values
        access(1'b1, 17'h00000, 8'h00, 1'b0, r);
        access(1'b1, 17'h1FFFF, 8'hFF, 1'b0, r);
        access(1'b0, 17'h1FFFF, 8'h00, 1'b0, r);
        chk(r == 8'hFF, "R9 read top address", r, 8'hFF);
        access(1'b0, 17'h00000, 8'h00, 1'b0, r);
        chk(r == 8'h00, "R9 read address zero", r, 8'h00);
        // R10: stray request while busy writes nothing
        access(1'b1, 17'h00020, 8'h3C, 1'b1, r);
        access(1'b0, 17'h00020 ^ 17'h00015, 8'h00, 1'b0, r);
        chk(r == exp_read(17'h00035), "R10 busy request ignored", r, exp_read(17'h00035));
        // R8: read immediately followed by write
        access(1'b0, 17'h00020, 8'h00, 1'b0, r);
        chk(r == 8'h3C, "R9 read after write", r, 8'h3C);
        access(1'b1, 17'h00021, 8'h5A, 1'b0, r);
        // Random traffic
        for (int k = 0; k < 80; k++) begin
            bit w;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            w = 1'($urandom % 2);
            a = AW'($urandom);
            d = DW'($urandom);
            access(w, a, d, 1'b0, r);
            if (!w) chk(r == exp_read(a), "R4 R9 random read data", r, exp_read(a));
        end
        chk(viol_strobe == 0, "R4 R5 strobe sequence", viol_strobe, 0);
        chk(viol_bus == 0, "R7 R8 bus ownership", viol_bus, 0);
        chk(viol_addr == 0, "R6 address and data hold", viol_addr, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule